// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Unit

This block produces a coarse scaling value for iterative division and square-root loops. It does not compute a true reciprocal. For a single- or double-precision operand it keeps the sign, replaces the exponent with its bitwise complement and clears every fraction bit. A zero or subnormal operand, whose exponent field is all zeros, gets a fixed exponent one below all-ones instead. NaN operands go down a separate path. A signalling NaN is quieted and raises an invalid-operation flag. A quiet NaN is passed through unchanged. In default-NaN mode, every NaN operand yields the canonical default NaN.

A precision select picks the operand format. The 32-bit format uses only the low half of the operand bus, and the high half of the result is forced to zero. Each accepted operand produces a registered result one cycle later, with a matching valid strobe. Invalid-operation events collect in a sticky status bit that only an explicit clear input resets.

Top module: `frx_unit`

## Requirements
- R1: For a non-NaN operand the result sign equals the operand sign and every fraction bit of the result is zero (23 bits single, 52 bits double).
- R2: An operand whose exponent field is zero (zero or subnormal) yields result exponent 0xFE in single precision (bits 30:23) or 0x7FE in double precision (bits 62:52).
- R3: Any other non-NaN operand, infinity included, yields the bitwise complement of its exponent field. An infinity therefore becomes a signed zero.
- R4: A signalling NaN (exponent all ones, fraction nonzero, fraction MSB clear) returns the operand with its fraction MSB (bit 22 single, bit 51 double) set and raises the invalid flag.
- R5: A quiet NaN (fraction MSB set) is returned bit for bit and raises no flag.
- R6: With default_nan high, any NaN operand returns 0x7FC00000 (single) or 0x7FF8000000000000 (double). A signalling NaN still raises the invalid flag in this mode.
- R7: dbl_sel=1 selects the 64-bit format. dbl_sel=0 selects the 32-bit format on op_a[31:0], ignores op_a[63:32] and drives res_q[63:32] to zero.
- R8: When in_valid is high, res_q and out_valid are updated at the next rising edge. When in_valid is low, out_valid falls and res_q holds its value.
- R9: inv_flag is set by an accepted operand that raises invalid and holds until flag_clr is high. If flag_clr and a new invalid event occur in the same cycle, the flag ends set.
- R10: While rst_n is low, res_q, out_valid and inv_flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand is presented this cycle |
| dbl_sel | input | 1 | 1: 64-bit format, 0: 32-bit format |
| default_nan | input | 1 | Replace every NaN result with the default NaN |
| flag_clr | input | 1 | Clear the sticky invalid flag |
| op_a | input | 64 | Operand |
| res_q | output | 64 | Registered result |
| out_valid | output | 1 | res_q was updated at the last edge |
| inv_flag | output | 1 | Sticky invalid-operation status |

## Verification
The assertions check several properties on every cycle: sign preservation and zero fraction for non-NaN operands, the quiet bit on propagated NaNs, the zeroed high half in single mode, the one-cycle valid strobe with result hold, and the set, hold and clear behaviour of the sticky flag. Only the bench's scenarios can confirm the exact exponent values: the complement for normal operands, the 0xFE/0x7FE substitution, infinity mapping to signed zero, and the bit patterns of default NaNs. Ignoring the high operand half in single mode is also shown only there.

// File: rtl/frx_pkg.sv
package frx_pkg;
    localparam int DATA_W   = 64;
    localparam int S_EXP_W  = 8;
    localparam int S_FRAC_W = 23;
    localparam int D_EXP_W  = 11;
    localparam int D_FRAC_W = 52;
    localparam int S_W      = 1 + S_EXP_W + S_FRAC_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              sticky;
    } frx_state_t;
endpackage

// File: rtl/frx_classify.sv
module frx_classify #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW-1:0] exp_f,
    input  logic [FW-1:0] frac_f,
    output logic          is_nan,
    output logic          is_snan,
    output logic          exp_zero
);
    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones = &exp_f;
        frac_nz  = |frac_f;
        exp_zero = ~|exp_f;
        is_nan   = exp_ones && frac_nz;
        is_snan  = is_nan && !frac_f[FW-1];
    end
endmodule

// File: rtl/frx_lane.sv
module frx_lane #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] a,
    input  logic           dn_mode,
    output logic [EW+FW:0] res,
    output logic           invalid
);
    localparam int W = 1 + EW + FW;
    localparam logic [EW-1:0] ZERO_EXP_SUB = {{(EW-1){1'b1}}, 1'b0};
    localparam logic [W-1:0]  QUIET_BIT    = W'(1) << (FW - 1);
    localparam logic [W-1:0]  DEF_NAN      = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    logic          sgn;
    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;
    logic          is_nan, is_snan, exp_zero;

    assign sgn    = a[W-1];
    assign exp_f  = a[W-2:FW];
    assign frac_f = a[FW-1:0];

    frx_classify #(.EW(EW), .FW(FW)) u_cls (
        .exp_f   (exp_f),
        .frac_f  (frac_f),
        .is_nan  (is_nan),
        .is_snan (is_snan),
        .exp_zero(exp_zero)
    );

    always_comb begin
        if (is_nan) begin
            invalid = is_snan;
            res     = dn_mode ? DEF_NAN : (a | QUIET_BIT);
        end else begin
            invalid = 1'b0;
            res     = {sgn, (exp_zero ? ZERO_EXP_SUB : ~exp_f), {FW{1'b0}}};
        end
    end

    always_comb begin
        if (!is_nan) begin
            AST_FRAC_CLEARED: assert (res[FW-1:0] == '0);      // R1
            AST_SIGN_KEPT:    assert (res[W-1] == a[W-1]);     // R1
        end
        if (is_nan && !dn_mode) begin
            AST_QUIET_SET:    assert (res[FW-1]);              // R4
        end
    end
endmodule

// File: rtl/frx_unit.sv
module frx_unit
    import frx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dbl_sel,
    input  logic              default_nan,
    input  logic              flag_clr,
    input  logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] res_q,
    output logic              out_valid,
    output logic              inv_flag
);
    localparam int HI_W = DATA_W - S_W;

    logic [S_W-1:0]    s_res;
    logic [DATA_W-1:0] d_res;
    logic              s_inv, d_inv;
    logic [DATA_W-1:0] sel_res;
    logic              sel_inv;
    frx_state_t        st_d, st_q;

    frx_lane #(.EW(S_EXP_W), .FW(S_FRAC_W)) u_sgl (
        .a      (op_a[S_W-1:0]),
        .dn_mode(default_nan),
        .res    (s_res),
        .invalid(s_inv)
    );

    frx_lane #(.EW(D_EXP_W), .FW(D_FRAC_W)) u_dbl (
        .a      (op_a),
        .dn_mode(default_nan),
        .res    (d_res),
        .invalid(d_inv)
    );

    always_comb begin
        sel_res = dbl_sel ? d_res : {{HI_W{1'b0}}, s_res};
        sel_inv = dbl_sel ? d_inv : s_inv;

        st_d        = st_q;
        st_d.vld    = in_valid;
        if (in_valid) begin
            st_d.res = sel_res;
        end
        st_d.sticky = (flag_clr ? 1'b0 : st_q.sticky) | (in_valid & sel_inv);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q     = st_q.res;
    assign out_valid = st_q.vld;
    assign inv_flag  = st_q.sticky;

    AST_SINGLE_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !dbl_sel |=> res_q[DATA_W-1:S_W] == '0);                 // R7
    AST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                            // R8
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(res_q));                        // R8
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        inv_flag && !flag_clr |=> inv_flag);                                // R9
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (dbl_sel ? d_inv : s_inv) |=> inv_flag);                // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !(in_valid && (dbl_sel ? d_inv : s_inv)) |=> !inv_flag); // R9
endmodule

// File: tb/sim_frx_unit.sv
`timescale 1ns/1ps
module sim_frx_unit;
    typedef struct packed {
        logic        dbl;
        logic        dn;
        logic [63:0] a;
        logic [63:0] exp_res;
        logic        exp_inv;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, 1'b0}, // R3
        '{1'b0, 1'b0, 64'h0000_0000_C049_0FDB, 64'h0000_0000_BF80_0000, 1'b0}, // R1 R3
        '{1'b0, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_7F00_0000, 1'b0}, // R2
        '{1'b0, 1'b0, 64'h0000_0000_8000_0001, 64'h0000_0000_FF00_0000, 1'b0}, // R2
        '{1'b0, 1'b0, 64'h0000_0000_7F80_0000, 64'h0000_0000_0000_0000, 1'b0}, // R3 inf
        '{1'b0, 1'b0, 64'h0000_0000_FF80_0000, 64'h0000_0000_8000_0000, 1'b0}, // R3 -inf
        '{1'b0, 1'b0, 64'h0000_0000_7F80_0001, 64'h0000_0000_7FC0_0001, 1'b1}, // R4
        '{1'b0, 1'b0, 64'h0000_0000_FFC0_1234, 64'h0000_0000_FFC0_1234, 1'b0}, // R5
        '{1'b0, 1'b1, 64'h0000_0000_7FA0_0000, 64'h0000_0000_7FC0_0000, 1'b1}, // R6
        '{1'b0, 1'b1, 64'h0000_0000_FFC0_0001, 64'h0000_0000_7FC0_0000, 1'b0}, // R6
        '{1'b0, 1'b0, 64'hDEAD_BEEF_3F80_0000, 64'h0000_0000_4000_0000, 1'b0}, // R7
        '{1'b1, 1'b0, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0}, // R3
        '{1'b1, 1'b0, 64'h0000_0000_0000_0000, 64'h7FE0_0000_0000_0000, 1'b0}, // R2
        '{1'b1, 1'b0, 64'h8000_0000_0000_0005, 64'hFFE0_0000_0000_0000, 1'b0}, // R2
        '{1'b1, 1'b0, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0001, 1'b1}, // R4
        '{1'b1, 1'b0, 64'hFFF8_0000_0000_0ABC, 64'hFFF8_0000_0000_0ABC, 1'b0}, // R5
        '{1'b1, 1'b1, 64'h7FF8_0000_0000_0002, 64'h7FF8_0000_0000_0000, 1'b0}, // R6
        '{1'b1, 1'b0, 64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0}, // R3
        '{1'b1, 1'b0, 64'hC010_0000_0000_0000, 64'hBFE0_0000_0000_0000, 1'b0}  // R1 R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dbl_sel = 1'b0;
    logic        default_nan = 1'b0;
    logic        flag_clr = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] res_q;
    logic        out_valid;
    logic        inv_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frx_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_sel(dbl_sel),
        .default_nan(default_nan), .flag_clr(flag_clr), .op_a(op_a),
        .res_q(res_q), .out_valid(out_valid), .inv_flag(inv_flag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic d, input logic dn,
                        input logic clr, input logic [63:0] a);
        @(negedge clk);
        in_valid = v; dbl_sel = d; default_nan = dn; flag_clr = clr; op_a = a;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 res", res_q, 64'h0);
        chk("R10 valid", {63'b0, out_valid}, 64'h0);
        chk("R10 flag", {63'b0, inv_flag}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i].dbl, VEC[i].dn, 1'b1, VEC[i].a);
            chk($sformatf("R1-3/R4-7 vec%0d res", i), res_q, VEC[i].exp_res);
            chk($sformatf("R4/R9 vec%0d flag", i), {63'b0, inv_flag}, {63'b0, VEC[i].exp_inv});
            chk($sformatf("R8 vec%0d valid", i), {63'b0, out_valid}, 64'h1);
        end

        // R8: idle cycle holds result, strobe low
        step(1'b0, 1'b0, 1'b0, 1'b1, 64'h0000_0000_3F80_0000);
        chk("R8 hold res", res_q, 64'hBFE0_0000_0000_0000);
        chk("R8 strobe low", {63'b0, out_valid}, 64'h0);

        // R9: sNaN not accepted does not set flag
        step(1'b0, 1'b0, 1'b0, 1'b0, 64'h0000_0000_7F80_0001);
        chk("R9 no set when idle", {63'b0, inv_flag}, 64'h0);

        // R9: set, then holds across clean operands
        step(1'b1, 1'b1, 1'b0, 1'b0, 64'h7FF4_0000_0000_0000);
        chk("R4 dbl snan res", res_q, 64'h7FFC_0000_0000_0000);
        chk("R9 set", {63'b0, inv_flag}, 64'h1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 64'h0000_0000_3F80_0000);
        chk("R9 held", {63'b0, inv_flag}, 64'h1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 64'h0000_0000_7FC0_0000);
        chk("R9 held after qnan", {63'b0, inv_flag}, 64'h1);
        step(1'b0, 1'b0, 1'b0, 1'b1, 64'h0);
        chk("R9 cleared", {63'b0, inv_flag}, 64'h0);

        // R6 + R9: default-NaN sNaN still flags, upper half ignored in single
        step(1'b1, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_FF80_0010);
        chk("R6 dn snan res", res_q, 64'h0000_0000_7FC0_0000);
        chk("R6 dn snan flag", {63'b0, inv_flag}, 64'h1);

        // R10: reset mid-run clears state
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R10 re-reset res", res_q, 64'h0);
        chk("R10 re-reset flag", {63'b0, inv_flag}, 64'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule